// File: doc/BRIEF.md
# Keyed-Refresh Watchdog Timer

This block is a memory-mapped watchdog. Software programs an expiry action and an interval, then sets the enable bit. From that point a down-counter counts a half-second tick that arrives from outside the block. Software must refresh the count before it reaches zero. A refresh is accepted only when the write carries a fixed 12-bit key next to the refresh bit, so a stray write to the control word cannot keep a failed system alive.

The interval is a 4-bit code with a non-linear scale. Code 0 gives half a second. Codes 1 to 6 give whole seconds. Codes 7 to 11 step by two seconds up to sixteen, and the reserved codes 12 to 15 act as code 11. On expiry the configured action is taken. Action 1 sends a single-cycle system reset request. Actions 2 and 3 raise an interrupt that stays high until it is serviced. Action 0 expires silently.

A three-state controller governs the block:
- **OFF**: the block is idle and ticks are ignored.
- **COUNT**: the counter runs.
- **FIRED**: the block has expired and holds.

The transitions are:
- **start**: OFF to COUNT, on a write to the mode register with the enable bit set.
- **stop**: COUNT or FIRED to OFF, on a write to the mode register with the enable bit clear.
- **reload**: COUNT to COUNT or FIRED to COUNT, on a keyed refresh.
- **retime**: COUNT to COUNT, on a mode write that changes the interval code.
- **step**: COUNT to COUNT, on a tick while the count is above one.
- **expire**: COUNT to FIRED, on a tick when the count is one.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, rst_req and irq are low, and both the mode and configuration registers read 0. The interval code is therefore 0 and the block is disabled.
- R2: The register offsets are 0x10 for control, 0x14 for configuration and 0x18 for mode. Configuration and mode read back all 32 written bits. Control always reads 0. Any other offset reads 0.
- R3: Writing mode bit 0 = 1 while disabled starts a full interval. A mode write with bit 0 = 0 stops the block and clears irq. Ticks have no effect while the block is disabled.
- R4: The interval code is mode bits [7:4], counted in half-second ticks. Code 0 gives 1 tick. Codes 1 to 6 give 2×code ticks. Codes 7 to 11 give 4×code−12 ticks. Codes 12 to 15 give 32 ticks.
- R5: A refresh happens only on a control write with bit 0 = 1 and bits [12:1] = 0xA57 (low 13 bits 0x14AF). It restarts a full interval. Any other control write leaves the count unchanged.
- R6: A mode write that keeps the interval code while already enabled does not disturb the count. A mode write that changes the code while counting restarts the count with the new interval.
- R7: When configuration bits [1:0] = 1, the tick that ends the interval causes rst_req to go high for exactly one cycle, starting in the cycle after that tick. irq stays low.
- R8: When configuration bits [1:0] are 2 or 3, expiry sets irq, which stays high until a keyed refresh or a stop.
- R9: When configuration bits [1:0] = 0, expiry drives neither output.
- R10: After expiry, further ticks produce no new rst_req pulse. A keyed refresh starts a new full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_half_sec | input | 1 | One-cycle pulse every half second |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | Single-cycle system reset request |
| irq | output | 1 | Latched expiry interrupt |

## Verification
The checker watches several properties on every cycle:
- the reset request is a single cycle, never overlaps the interrupt, and always follows a tick;
- the interrupt rises only after a tick and holds until a keyed refresh or a stop;
- a stop clears both outputs;
- the control word reads as zero, and the mode register reads back the value just written.

Some behaviours depend on a history of many ticks, so only the bench scenarios can show them:
- the exact tick count for every interval code;
- the rejection of wrong keys;
- an enable rewrite that leaves the count undisturbed, and a code change that restarts it;
- the silent expiry of action 0.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int WD_DATA_W   = 32;
    localparam int WD_CNT_W    = 6;
    localparam int WD_CODE_W   = 4;
    localparam int WD_CODE_LSB = 4;
    localparam int WD_ACT_W    = 2;
    localparam int WD_KEY_W    = 12;
    localparam logic [WD_KEY_W-1:0] WD_KEY = 12'hA57;
    localparam int WD_OFS_CTRL = 'h10;
    localparam int WD_OFS_CFG  = 'h14;
    localparam int WD_OFS_MODE = 'h18;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_e;

    // interval code -> number of half-second ticks
    function automatic logic [WD_CNT_W-1:0] wd_halves(input logic [WD_CODE_W-1:0] code);
        logic [WD_CNT_W-1:0] c;
        c = WD_CNT_W'(code);
        if (code == '0)
            return WD_CNT_W'(1);
        else if (code <= 4'd6)
            return c << 1;
        else if (code <= 4'd11)
            return (c << 2) - WD_CNT_W'(12);
        else
            return WD_CNT_W'(32);
    endfunction
endpackage

// File: rtl/wdk_regfile.sv
module wdk_regfile
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WD_DATA_W-1:0] bus_wdata,
    output logic [WD_DATA_W-1:0] bus_rdata,
    output logic [WD_DATA_W-1:0] mode_q,
    output logic [WD_DATA_W-1:0] cfg_q,
    output logic                 kick,
    output logic                 mode_wr,
    output logic                 code_chg
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WD_OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(WD_OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(WD_OFS_MODE);
    localparam int CODE_MSB = WD_CODE_LSB + WD_CODE_W - 1;

    logic cfg_wr;

    assign cfg_wr   = bus_we && (bus_addr == A_CFG);
    assign mode_wr  = bus_we && (bus_addr == A_MODE);
    assign kick     = bus_we && (bus_addr == A_CTRL) && bus_wdata[0]
                      && (bus_wdata[WD_KEY_W:1] == WD_KEY);
    assign code_chg = bus_wdata[CODE_MSB:WD_CODE_LSB] != mode_q[CODE_MSB:WD_CODE_LSB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (mode_wr) mode_q <= bus_wdata;
            if (cfg_wr)  cfg_q  <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CFG:   bus_rdata = cfg_q;
            A_MODE:  bus_rdata = mode_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdk_core.sv
module wdk_core
    import wdk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 mode_wr,
    input  logic                 en_new,
    input  logic [WD_CODE_W-1:0] code_new,
    input  logic [WD_CODE_W-1:0] code_cur,
    input  logic                 code_chg,
    input  logic                 kick,
    input  logic [WD_ACT_W-1:0]  action,
    output logic                 rst_req,
    output logic                 irq
);
    wd_state_e           st_q, st_d;
    logic [WD_CNT_W-1:0] cnt_q, cnt_d;
    logic                fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WD_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (st_q)
            WD_OFF: begin
                cnt_d = '0;
                if (mode_wr && en_new) begin          // start
                    st_d  = WD_COUNT;
                    cnt_d = wd_halves(code_new);
                end
            end
            WD_COUNT: begin
                if (mode_wr && !en_new) begin         // stop
                    st_d  = WD_OFF;
                    cnt_d = '0;
                end else if (mode_wr && code_chg) begin
                    cnt_d = wd_halves(code_new);      // retime
                end else if (kick) begin
                    cnt_d = wd_halves(code_cur);      // reload
                end else if (tick) begin
                    if (cnt_q <= WD_CNT_W'(1)) begin  // expire
                        st_d  = WD_FIRED;
                        cnt_d = '0;
                        fire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - WD_CNT_W'(1); // step
                    end
                end
            end
            WD_FIRED: begin
                if (mode_wr && !en_new) begin         // stop
                    st_d = WD_OFF;
                end else if (kick) begin              // reload
                    st_d  = WD_COUNT;
                    cnt_d = wd_halves(code_cur);
                end
            end
            default: begin
                st_d  = WD_OFF;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= fire && (action == WD_ACT_W'(1));
            irq     <= (st_d == WD_FIRED) && (irq || (fire && action[1]));
        end
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_half_sec,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam int CODE_MSB = WD_CODE_LSB + WD_CODE_W - 1;

    logic [WD_DATA_W-1:0] mode_q, cfg_q;
    logic                 kick, mode_wr, code_chg;

    wdk_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode_q    (mode_q),
        .cfg_q     (cfg_q),
        .kick      (kick),
        .mode_wr   (mode_wr),
        .code_chg  (code_chg)
    );

    wdk_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_half_sec),
        .mode_wr  (mode_wr),
        .en_new   (bus_wdata[0]),
        .code_new (bus_wdata[CODE_MSB:WD_CODE_LSB]),
        .code_cur (mode_q[CODE_MSB:WD_CODE_LSB]),
        .code_chg (code_chg),
        .kick     (kick),
        .action   (cfg_q[WD_ACT_W-1:0]),
        .rst_req  (rst_req),
        .irq      (irq)
    );
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_half_sec,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rst_req,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WD_OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(WD_OFS_MODE);

    logic stop_wr, key_wr;
    assign stop_wr = bus_we && (bus_addr == A_MODE) && !bus_wdata[0];
    assign key_wr  = bus_we && (bus_addr == A_CTRL) && (bus_wdata[12:0] == 13'h14AF);

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                            // R7
    AST_RST_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(tick_half_sec));                                // R7
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq));                                               // R7
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_half_sec));                             // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stop_wr && !key_wr) |=> irq);                            // R8
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!irq && !rst_req));                                  // R3
    AST_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata == 32'h0));                   // R2
    AST_MODE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_we && (bus_addr == A_MODE)) && (bus_addr == A_MODE))
            |-> (bus_rdata == $past(bus_wdata)));                         // R2
endmodule

bind wdog_keyed wdk_chk #(.ADDR_W(ADDR_W)) u_wdk_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_half_sec (tick_half_sec),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .rst_req       (rst_req),
    .irq           (irq)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req, irq;

    int n_chk = 0, n_fail = 0, rst_cnt = 0;

    always #2 clk = ~clk;

    wdog_keyed i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .tick_half_sec(tick), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .rst_req(rst_req), .irq(irq)
    );

    // behavioural reference: phase 0 off, 1 counting, 2 expired
    int          m_phase, m_left;
    logic [31:0] m_mode, m_cfg;
    logic        m_rst, m_irq;

    function automatic int exp_halves(int code);
        if (code == 0) return 1;
        if (code <= 6) return 2 * code;
        if (code <= 11) return 2 * (8 + 2 * (code - 7));
        return 32;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_mode = 0; m_cfg = 0; m_rst = 0; m_irq = 0;
        end else begin
            automatic bit key = we && addr == 8'h10 && wdata[12:0] == 13'h14AF;
            automatic bit mw  = we && addr == 8'h18;
            automatic bit hit = 0;
            automatic int ncode = int'(wdata[7:4]);
            automatic int ocode = int'(m_mode[7:4]);
            if (m_phase == 0) begin
                if (mw && wdata[0]) begin m_phase = 1; m_left = exp_halves(ncode); end
            end else if (mw && !wdata[0]) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                if (mw && ncode != ocode) m_left = exp_halves(ncode);
                else if (key) m_left = exp_halves(ocode);
                else if (tick) begin
                    m_left--;
                    if (m_left <= 0) begin m_phase = 2; hit = 1; end
                end
            end else if (key) begin
                m_phase = 1; m_left = exp_halves(ocode);
            end
            m_rst = hit && m_cfg[1:0] == 2'd1;
            m_irq = (m_phase == 2) && (m_irq || (hit && m_cfg[1:0] >= 2'd2));
            if (mw) m_mode = wdata;
            if (we && addr == 8'h14) m_cfg = wdata;
        end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(rst_req == m_rst, "R7/R9", "rst_req vs model", rst_req, m_rst);
            check(irq == m_irq, "R8/R9", "irq vs model", irq, m_irq);
        end
        if (rst_req) rst_cnt++;
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk); addr = a; #1;
        check(rdata == exp, tag, "read", rdata, exp);
        addr = 8'h00;
    endtask

    task automatic pulse();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_up();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(rst_req == 0, "R1", "rst_req after reset", rst_req, 0);
        check(irq == 0, "R1", "irq after reset", irq, 0);
        rd(8'h18, 32'h0, "R1");
        rd(8'h14, 32'h0, "R1");
        // R3 ticks while disabled do nothing
        base = rst_cnt;
        pulses(3);
        check(rst_cnt == base && irq == 0, "R3", "ticks while off", rst_cnt - base, 0);
        // R2 readback
        wr(8'h10, 32'h0000_14AF);
        rd(8'h10, 32'h0, "R2");
        wr(8'h14, 32'h1234_5671);
        rd(8'h14, 32'h1234_5671, "R2");
        wr(8'h18, 32'hABCD_0030);
        rd(8'h18, 32'hABCD_0030, "R2");
        rd(8'h1C, 32'h0, "R2");
        // R4 every interval code, action 1 (R7)
        for (int c = 0; c < 16; c++) begin
            int n;
            wr(8'h18, 32'h0);
            wr(8'h14, 32'h1);
            wr(8'h18, (c << 4) | 1);
            base = rst_cnt; n = 0;
            while (rst_cnt == base && n < 40) begin pulse(); n++; end
            check(n == exp_halves(c), "R4", $sformatf("ticks for code %0d", c), n, exp_halves(c));
            check(rst_cnt == base + 1, "R7", "single rst pulse", rst_cnt - base, 1);
            // R10 no further pulses after expiry
            pulses(3);
            check(rst_cnt == base + 1, "R10", "no pulse after expiry", rst_cnt - base, 1);
        end
        // R5 wrong keys are ignored
        wr(8'h18, 32'h0); wr(8'h18, 32'h11);       // code 1: 2 ticks
        pulse();
        wr(8'h10, 32'h0000_14AE);                   // bit0 clear
        wr(8'h10, 32'h0000_14AD);                   // bad key
        base = rst_cnt;
        pulse();
        check(rst_cnt == base + 1, "R5", "bad key no refresh", rst_cnt - base, 1);
        // R10 refresh after expiry restarts full interval
        wr(8'h10, 32'h0000_14AF);
        base = rst_cnt;
        pulse();
        check(rst_cnt == base, "R10", "refresh restarts", rst_cnt - base, 0);
        // R5 good key refreshes
        wr(8'h10, 32'hFFFF_E000 | 32'h14AF);
        pulse();
        check(rst_cnt == base, "R5", "good key refresh", rst_cnt - base, 0);
        pulse();
        check(rst_cnt == base + 1, "R5", "expiry after refresh", rst_cnt - base, 1);
        // R6 enable rewrite does not disturb
        wr(8'h18, 32'h0); wr(8'h18, 32'h21);       // code 2: 4 ticks
        pulses(3);
        wr(8'h18, 32'h21);
        base = rst_cnt;
        pulse();
        check(rst_cnt == base + 1, "R6", "rewrite keeps count", rst_cnt - base, 1);
        // R6 code change restarts with new interval
        wr(8'h18, 32'h0); wr(8'h18, 32'h21);
        pulses(3);
        wr(8'h18, 32'h11);
        base = rst_cnt;
        pulse();
        check(rst_cnt == base, "R6", "retime first tick", rst_cnt - base, 0);
        pulse();
        check(rst_cnt == base + 1, "R6", "retime expiry", rst_cnt - base, 1);
        // R8 interrupt action, cleared by refresh then by stop
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h2);
        wr(8'h18, 32'h01);
        pulse();
        check(irq == 1, "R8", "irq set", irq, 1);
        pulses(4);
        check(irq == 1, "R8", "irq held", irq, 1);
        wr(8'h10, 32'h14AF);
        check(irq == 0, "R8", "irq cleared by refresh", irq, 0);
        wr(8'h14, 32'h3);
        pulse();
        check(irq == 1, "R8", "irq action 3", irq, 1);
        wr(8'h18, 32'h0);
        check(irq == 0, "R3", "irq cleared by stop", irq, 0);
        // R9 silent expiry
        wr(8'h14, 32'h0);
        base = rst_cnt;
        wr(8'h18, 32'h01);
        pulses(3);
        check(rst_cnt == base && irq == 0, "R9", "silent expiry", rst_cnt - base, 0);
        wr(8'h18, 32'h0);
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule